// File: doc/BRIEF.md
# BCD Calendar Clock on a Byte Bus

The block is a calendar clock that sits in the top eight byte addresses of a 13-bit, byte-wide address space. The addresses below it are plain read/write storage. Time advances on a tick-enable input that pulses at the reference rate of 32,768 Hz. It keeps seconds, minutes and 24-hour hours, a day-of-week count, the date, the month, a two-digit year and a small century counter. Every field except the century is in packed BCD. The end of each month is handled for 28, 29, 30 and 31 days, and the leap-year choice comes from the BCD year.

Software sees the time through a set of user bytes that is separate from the running counters. The lowest clock byte is a control byte. One control bit freezes the user bytes so that a consistent time can be read while the counters run on underneath. Another control bit makes the user bytes writable; clearing that bit loads them into the counters. The control byte also carries a signed 5-bit trim. The trim lengthens or shortens one second in every calibration window. A stop bit in the seconds byte halts all counting.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset the clock bytes read 1FF8h=00h (control), 1FF9h=00h, 1FFAh=00h, 1FFBh=00h, 1FFCh=01h, 1FFDh=01h, 1FFEh=01h and 1FFFh=00h.
- R2: A read to an address below 1FF8h returns, one cycle after the request, the byte last written to any address that shares the same low STORE_AW bits.
- R3: Each second lasts TICKS_PER_SEC tick pulses counted from the last load. Seconds 59h wrap to 00h and carry into minutes. Minutes 59h carry into hours. Hours 23h wrap to 00h and advance both the date and the day of week, which goes from 7 back to 1.
- R4: At the end of the last day of a month the date returns to 01h and the month advances. The last day is 30h for months 04h, 06h, 09h and 11h; 31h for the other months; 29h for month 02h when the BCD year is a multiple of four, and 28h otherwise.
- R5: At the end of 31 December the month returns to 01h and the BCD year increments. Year 99h wraps to 00h and adds one to the 2-bit century field, bits 5:4 of 1FFCh.
- R6: While control bit 7 is set, reads of the clock bytes stay frozen and writes to 1FF9h–1FFFh update them. Writing the control byte with bit 7 cleared loads those bytes into the counters and restarts the current second.
- R7: A write to 1FF9h–1FFFh while control bit 7 is clear changes nothing that can be read back.
- R8: While control bit 6 is set and bit 7 is clear, the clock bytes hold a snapshot and the counters keep running. After bit 6 clears, reads show the advanced time.
- R9: Seconds are numbered from the last load. The second that completes each group of CAL_SECS seconds lasts TICKS_PER_SEC minus the trim (control bits 4:0) when control bit 5 is 1, and TICKS_PER_SEC plus the trim when bit 5 is 0.
- R10: While bit 7 of the loaded seconds byte is 1, the time does not advance, and 1FF9h reads back with bit 7 set.
- R11: Byte layout: 1FF9h {stop, sec[6:0]}, 1FFAh {0, min[6:0]}, 1FFBh {00, hour[5:0]}, 1FFCh {00, century[1:0], 0, day[2:0]}, 1FFDh {00, date[5:0]}, 1FFEh {000, month[4:0]}, 1FFFh year[7:0]. Bits marked 0 read as 0. The control byte reads back as it was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle timebase enable at the reference rate |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered one cycle after a read request |

## Verification
The hardest states to reach from the ports are the month, year and century boundaries and the one trimmed second at the end of a calibration window. In normal running each of them lies days or years of ticks away. The stimulus uses the write-enable control bit to load a time one second before each boundary. Because loading restarts the second, the bench then delivers an exact number of tick pulses and reads the result with the tick held low. For the trim, the bench applies one tick fewer than the window needs, checks the result, then applies one more. A behavioural model running alongside predicts the read data on every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic       stop;
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [2:0] dow;
    logic [1:0] cent;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{stop: 1'b0, sec: 7'h00, min: 7'h00, hour: 6'h00,
                                      dow: 3'd1, cent: 2'd0, date: 6'h01, mon: 5'h01,
                                      year: 8'h00};

  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_SEC  = 3'd1;
  localparam logic [2:0] IDX_MIN  = 3'd2;
  localparam logic [2:0] IDX_HOUR = 3'd3;
  localparam logic [2:0] IDX_DOW  = 3'd4;
  localparam logic [2:0] IDX_DATE = 3'd5;
  localparam logic [2:0] IDX_MON  = 3'd6;
  localparam logic [2:0] IDX_YEAR = 3'd7;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = v + 8'd1;
  endfunction

  // multiple of four in BCD: even tens -> units 0/4/8, odd tens -> units 2/6
  function automatic logic leap_year(input logic [7:0] y);
    if (y[4]) leap_year = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      leap_year = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [5:0] last_date(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                      last_date = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_date = 6'h30;
      default:                    last_date = 6'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_rd(input rtc_time_t t, input logic [2:0] idx);
    case (idx)
      IDX_SEC:  field_rd = {t.stop, t.sec};
      IDX_MIN:  field_rd = {1'b0, t.min};
      IDX_HOUR: field_rd = {2'b0, t.hour};
      IDX_DOW:  field_rd = {2'b0, t.cent, 1'b0, t.dow};
      IDX_DATE: field_rd = {2'b0, t.date};
      IDX_MON:  field_rd = {3'b0, t.mon};
      IDX_YEAR: field_rd = t.year;
      default:  field_rd = 8'h00;
    endcase
  endfunction

  function automatic rtc_time_t field_wr(input rtc_time_t t, input logic [2:0] idx,
                                         input logic [7:0] d);
    field_wr = t;
    case (idx)
      IDX_SEC:  begin field_wr.stop = d[7]; field_wr.sec = d[6:0]; end
      IDX_MIN:  field_wr.min  = d[6:0];
      IDX_HOUR: field_wr.hour = d[5:0];
      IDX_DOW:  begin field_wr.cent = d[5:4]; field_wr.dow = d[2:0]; end
      IDX_DATE: field_wr.date = d[5:0];
      IDX_MON:  field_wr.mon  = d[4:0];
      IDX_YEAR: field_wr.year = d;
      default:  ;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned CAL_SECS      = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [5:0] cal_i,
  output logic       sec_o
);
  localparam int unsigned PRE_W = $clog2(TICKS_PER_SEC + 32);
  localparam int unsigned WIN_W = (CAL_SECS > 1) ? $clog2(CAL_SECS) : 1;
  localparam logic [PRE_W-1:0] BASE     = PRE_W'(TICKS_PER_SEC);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(CAL_SECS - 1);

  logic [PRE_W-1:0] pre_q, div, trim;
  logic [WIN_W-1:0] win_q;

  assign trim = PRE_W'(cal_i[4:0]);

  always_comb begin
    div = BASE;
    if (win_q == WIN_LAST) div = cal_i[5] ? (BASE - trim) : (BASE + trim);
  end

  // >= keeps a trim change mid-second from skipping the wrap
  assign sec_o = run_i & tick_i & (pre_q >= div - PRE_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      win_q <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      win_q <= '0;
    end else if (run_i && tick_i) begin
      if (sec_o) begin
        pre_q <= '0;
        win_q <= (win_q == WIN_LAST) ? '0 : win_q + WIN_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      step_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t cnt_o
);
  rtc_time_t cnt_q, nxt;

  always_comb begin
    nxt = cnt_q;
    if (step_i) begin
      if (cnt_q.sec < 7'h59) nxt.sec = 7'(bcd_inc({1'b0, cnt_q.sec}));
      else begin
        nxt.sec = 7'h00;
        if (cnt_q.min < 7'h59) nxt.min = 7'(bcd_inc({1'b0, cnt_q.min}));
        else begin
          nxt.min = 7'h00;
          if (cnt_q.hour < 6'h23) nxt.hour = 6'(bcd_inc({2'b0, cnt_q.hour}));
          else begin
            nxt.hour = 6'h00;
            nxt.dow  = (cnt_q.dow >= 3'd7) ? 3'd1 : cnt_q.dow + 3'd1;
            if (cnt_q.date < last_date(cnt_q.mon, leap_year(cnt_q.year)))
              nxt.date = 6'(bcd_inc({2'b0, cnt_q.date}));
            else begin
              nxt.date = 6'h01;
              if (cnt_q.mon < 5'h12) nxt.mon = 5'(bcd_inc({3'b0, cnt_q.mon}));
              else begin
                nxt.mon = 5'h01;
                if (cnt_q.year != 8'h99) nxt.year = bcd_inc(cnt_q.year);
                else begin
                  nxt.year = 8'h00;
                  nxt.cent = cnt_q.cent + 2'd1;
                end
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RTC_RESET;
    else if (load_i) cnt_q <= load_val_i;
    else             cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rtc_store.sv
module rtc_store #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned STORE_AW      = 8,
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned CAL_SECS      = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  logic       clk_sel, wr, rd, ctrl_wr, fld_wr, load, sec_step;
  logic [2:0] idx;
  logic [7:0] ctrl_q, clk_byte, mem_rd;
  rtc_time_t  cnt, shd_q;

  assign clk_sel = &addr_i[ADDR_W-1:3];
  assign idx     = addr_i[2:0];
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign ctrl_wr = wr & clk_sel & (idx == IDX_CTRL);
  assign fld_wr  = wr & clk_sel & (idx != IDX_CTRL) & ctrl_q[7];
  assign load    = ctrl_wr & ctrl_q[7] & ~wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= 8'h00;
    else if (ctrl_wr) ctrl_q <= wdata_i;
  end

  // user-visible copy: tracks counters unless frozen by read or write bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        shd_q <= RTC_RESET;
    else if (fld_wr)                    shd_q <= field_wr(shd_q, idx, wdata_i);
    else if (!ctrl_q[7] && !ctrl_q[6])  shd_q <= cnt;
  end

  rtc_prescale #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .CAL_SECS     (CAL_SECS)
  ) i_prescale (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .run_i (~cnt.stop),
    .clr_i (load),
    .cal_i (ctrl_q[5:0]),
    .sec_o (sec_step)
  );

  rtc_calendar i_calendar (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (sec_step),
    .load_i    (load),
    .load_val_i(shd_q),
    .cnt_o     (cnt)
  );

  rtc_store #(.AW(STORE_AW)) i_store (
    .clk_i  (clk_i),
    .we_i   (wr & ~clk_sel),
    .addr_i (addr_i[STORE_AW-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(mem_rd)
  );

  assign clk_byte = (idx == IDX_CTRL) ? ctrl_q : field_rd(shd_q, idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= 8'h00;
    else if (rd) rdata_o <= clk_sel ? clk_byte : mem_rd;
  end

endmodule

// File: rtl/rtc_bcd_clock_chk.sv
module rtc_bcd_clock_chk
  import rtc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input rtc_time_t  cnt_i,
  input rtc_time_t  shd_i,
  input logic [7:0] ctrl_i,
  input logic       load_i
);

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_i == $past(shd_i)));

  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[6] && !ctrl_i[7]) |=> $stable(shd_i));

  p_stop_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i.stop && !load_i) |=> $stable(cnt_i));

  p_min_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ((cnt_i.min == $past(cnt_i.min)) || (cnt_i.sec == 7'h00)));

  p_date_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ((cnt_i.date == $past(cnt_i.date)) || (cnt_i.hour == 6'h00)));

  p_cent_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ((cnt_i.cent == $past(cnt_i.cent)) || (cnt_i.year == 8'h00)));

endmodule

bind rtc_bcd_clock rtc_bcd_clock_chk i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cnt_i (cnt),
  .shd_i (shd_q),
  .ctrl_i(ctrl_q),
  .load_i(load)
);

// File: tb/test_rtc_bcd_clock.sv
module test_rtc_bcd_clock;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 40;
  localparam int CALS       = 4;
  localparam int SAW        = 8;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rtc_bcd_clock #(
    .ADDR_W(13), .STORE_AW(SAW), .TICKS_PER_SEC(TPS), .CAL_SECS(CALS)
  ) i_rtc_bcd_clock (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  // ---------------- behavioural reference model ----------------
  int m_sec, m_min, m_hour, m_dow, m_cent, m_date, m_mon, m_year, m_stop;
  int m_pre, m_win, m_ctrl, m_div;
  int m_sh [8];
  int cb [8];
  int mask [8] = '{0, 255, 127, 63, 55, 63, 31, 255};
  logic [7:0] m_mem [1 << SAW];
  logic [7:0] m_rd;
  bit   sel, pulse;
  int   ix;

  function automatic int b2d(int v); return (v / 10) * 16 + (v % 10); endfunction
  function automatic int d2b(int v); return (v / 16) * 10 + (v % 16); endfunction

  function automatic int dim(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic m_advance();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hour++;
    if (m_hour < 24) return;
    m_hour = 0;
    m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
    m_date++;
    if (m_date <= dim(m_mon, m_year)) return;
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_year++;
    if (m_year < 100) return;
    m_year = 0; m_cent = (m_cent + 1) % 4;
  endtask

  task automatic m_reset();
    m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1; m_cent = 0;
    m_date = 1; m_mon = 1; m_year = 0; m_stop = 0;
    m_pre = 0; m_win = 0; m_ctrl = 0; m_rd = 8'h00;
    m_sh = '{0, 0, 0, 0, 1, 1, 1, 0};
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      cb[0] = 0;
      cb[1] = m_stop * 128 + b2d(m_sec);
      cb[2] = b2d(m_min);
      cb[3] = b2d(m_hour);
      cb[4] = m_cent * 16 + m_dow;
      cb[5] = b2d(m_date);
      cb[6] = b2d(m_mon);
      cb[7] = b2d(m_year);
      sel = (addr[12:3] == 10'h3FF);
      ix  = int'(addr[2:0]);
      if (req && !we)
        m_rd = sel ? 8'((ix == 0) ? m_ctrl : m_sh[ix]) : m_mem[addr[SAW-1:0]];
      pulse = 1'b0;
      if (m_stop == 0 && tick) begin
        m_div = TPS;
        if (m_win == CALS - 1)
          m_div = ((m_ctrl & 32) != 0) ? TPS - (m_ctrl & 31) : TPS + (m_ctrl & 31);
        if (m_pre >= m_div - 1) begin
          pulse = 1'b1; m_pre = 0; m_win = (m_win + 1) % CALS;
        end else m_pre++;
      end
      if (pulse) m_advance();
      if (req && we && sel && ix == 0 && (m_ctrl & 128) != 0 && !wdata[7]) begin
        m_stop = m_sh[1] / 128;
        m_sec  = d2b(m_sh[1] % 128);
        m_min  = d2b(m_sh[2]);
        m_hour = d2b(m_sh[3]);
        m_cent = (m_sh[4] / 16) % 4;
        m_dow  = m_sh[4] % 8;
        m_date = d2b(m_sh[5]);
        m_mon  = d2b(m_sh[6]);
        m_year = d2b(m_sh[7]);
        m_pre = 0; m_win = 0;
      end
      if (req && we && sel && ix != 0 && (m_ctrl & 128) != 0)
        m_sh[ix] = int'(wdata) & mask[ix];
      else if ((m_ctrl & 192) == 0)
        for (int k = 1; k < 8; k++) m_sh[k] = cb[k];
      if (req && we && sel && ix == 0) m_ctrl = int'(wdata);
      if (req && we && !sel) m_mem[addr[SAW-1:0]] = wdata;
    end
  end

  // model comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rdata !== m_rd) begin
        fails++;
        $display("FAIL R11 model rdata act=%h exp=%h t=%0t", rdata, m_rd, $time);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bus_wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic chk(input logic [12:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    bus_rd(a, got);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr=%h act=%h exp=%h", tag, a, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                          input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] yr, input logic [7:0] ctl);
    bus_wr(13'h1FF8, 8'h80 | ctl);
    bus_wr(13'h1FF9, s);
    bus_wr(13'h1FFA, mi);
    bus_wr(13'h1FFB, h);
    bus_wr(13'h1FFC, dw);
    bus_wr(13'h1FFD, dt);
    bus_wr(13'h1FFE, mo);
    bus_wr(13'h1FFF, yr);
    bus_wr(13'h1FF8, ctl & 8'h7F);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset contents
    chk(13'h1FF8, 8'h00, "R1 ctrl");
    chk(13'h1FF9, 8'h00, "R1 sec");
    chk(13'h1FFA, 8'h00, "R1 min");
    chk(13'h1FFB, 8'h00, "R1 hour");
    chk(13'h1FFC, 8'h01, "R1 dow");
    chk(13'h1FFD, 8'h01, "R1 date");
    chk(13'h1FFE, 8'h01, "R1 month");
    chk(13'h1FFF, 8'h00, "R1 year");

    // R2 storage and aliasing on low address bits
    bus_wr(13'h0000, 8'hA5);
    bus_wr(13'h1FF7, 8'h3C);
    bus_wr(13'h0005, 8'h11);
    chk(13'h0000, 8'hA5, "R2 low");
    chk(13'h1FF7, 8'h3C, "R2 top");
    chk(13'h0105, 8'h11, "R2 alias");

    // R3 carries through the day
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h15, 8'h06, 8'h23, 8'h00);
    ticks(TPS);
    chk(13'h1FF9, 8'h59, "R3 sec");
    ticks(TPS);
    chk(13'h1FF9, 8'h00, "R3 sec wrap");
    chk(13'h1FFA, 8'h00, "R3 min wrap");
    chk(13'h1FFB, 8'h00, "R3 hour wrap");
    chk(13'h1FFC, 8'h01, "R3 dow wrap");
    chk(13'h1FFD, 8'h16, "R3 date");

    // R4 month lengths
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23, 8'h00);
    ticks(TPS);
    chk(13'h1FFD, 8'h01, "R4 apr30 date");
    chk(13'h1FFE, 8'h05, "R4 apr30 mon");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h23, 8'h00);
    ticks(TPS);
    chk(13'h1FFD, 8'h31, "R4 jan30");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h01, 8'h23, 8'h00);
    ticks(TPS);
    chk(13'h1FFE, 8'h02, "R4 jan31");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23, 8'h00);
    ticks(TPS);
    chk(13'h1FFE, 8'h03, "R4 feb28 common");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24, 8'h00);
    ticks(TPS);
    chk(13'h1FFD, 8'h29, "R4 feb28 leap24");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h12, 8'h00);
    ticks(TPS);
    chk(13'h1FFD, 8'h29, "R4 feb28 leap12");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h10, 8'h00);
    ticks(TPS);
    chk(13'h1FFD, 8'h01, "R4 feb28 year10");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24, 8'h00);
    ticks(TPS);
    chk(13'h1FFE, 8'h03, "R4 feb29");

    // R5 year and century
    set_time(8'h59, 8'h59, 8'h23, 8'h13, 8'h31, 8'h12, 8'h19, 8'h00);
    ticks(TPS);
    chk(13'h1FFF, 8'h20, "R5 year bcd");
    chk(13'h1FFE, 8'h01, "R5 month");
    set_time(8'h59, 8'h59, 8'h23, 8'h13, 8'h31, 8'h12, 8'h99, 8'h00);
    ticks(TPS);
    chk(13'h1FFF, 8'h00, "R5 year wrap");
    chk(13'h1FFC, 8'h24, "R5 century");

    // R6 write bit
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h24, 8'h00);
    bus_wr(13'h1FF8, 8'h80);
    ticks(2 * TPS);
    chk(13'h1FF9, 8'h10, "R6 frozen");
    bus_wr(13'h1FF9, 8'h30);
    chk(13'h1FF9, 8'h30, "R6 staged");
    bus_wr(13'h1FF8, 8'h00);
    chk(13'h1FF9, 8'h30, "R6 loaded");
    ticks(TPS);
    chk(13'h1FF9, 8'h31, "R6 restart");

    // R7 write ignored with write bit clear
    bus_wr(13'h1FF9, 8'h45);
    bus_wr(13'h1FFF, 8'h77);
    chk(13'h1FF9, 8'h31, "R7 sec");
    chk(13'h1FFF, 8'h24, "R7 year");

    // R8 read bit
    bus_wr(13'h1FF8, 8'h40);
    ticks(2 * TPS);
    chk(13'h1FF9, 8'h31, "R8 snapshot");
    bus_wr(13'h1FF8, 8'h00);
    chk(13'h1FF9, 8'h33, "R8 resumed");

    // R9 calibration, shortened then lengthened window second
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h24, 8'h25);
    chk(13'h1FF8, 8'h25, "R9 ctrl readback");
    ticks(3 * TPS + 34);
    chk(13'h1FF9, 8'h03, "R9 short minus1");
    ticks(1);
    chk(13'h1FF9, 8'h04, "R9 short done");
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h24, 8'h05);
    ticks(3 * TPS + 44);
    chk(13'h1FF9, 8'h03, "R9 long minus1");
    ticks(1);
    chk(13'h1FF9, 8'h04, "R9 long done");
    ticks(TPS);
    chk(13'h1FF9, 8'h05, "R9 normal after");

    // R10 stop bit
    set_time(8'hA0, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h24, 8'h00);
    ticks(100);
    chk(13'h1FF9, 8'hA0, "R10 stopped");
    set_time(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h24, 8'h00);
    ticks(TPS);
    chk(13'h1FF9, 8'h21, "R10 running");

    // R11 field masks
    bus_wr(13'h1FF8, 8'h80);
    bus_wr(13'h1FFA, 8'hFF);
    bus_wr(13'h1FFB, 8'hFF);
    bus_wr(13'h1FFC, 8'hFF);
    bus_wr(13'h1FFD, 8'hFF);
    bus_wr(13'h1FFE, 8'hFF);
    chk(13'h1FFA, 8'h7F, "R11 min mask");
    chk(13'h1FFB, 8'h3F, "R11 hour mask");
    chk(13'h1FFC, 8'h37, "R11 dow mask");
    chk(13'h1FFD, 8'h3F, "R11 date mask");
    chk(13'h1FFE, 8'h1F, "R11 month mask");
    chk(13'h1FF8, 8'h80, "R11 ctrl");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule